// File: doc/BRIEF.md
# Loop Iterator and Accumulator Processing Element

This block extends one processing element of a word-level array so that it can produce the values a flattened loop nest needs. It yields outer-loop iterators, channel indices and running sums straight from a single register. It needs no division or modulo to rebuild them from a collapsed iteration count. The host stores three parameter words: a start value, a period and a ceiling. It then selects a mode, an ALU operation and the source of the step value. A start pulse arms the unit, and after that the register changes once per loop iteration, on an iteration strobe that the array raises every initiation interval.

A period counter counts iterations down and marks the last iteration of each period. In nested-iterator mode the value stays the same for a whole period and then steps. When it has reached the ceiling it falls back to the start value. In resetting mode the value returns to the start value at the beginning of each period. In leaping mode the start value is applied as a large step at each boundary, and the normal step is applied on the other iterations. A free mode applies the step on every iteration.

The controller is a two-state machine. ST_IDLE is entered at reset and ignores strobes. A start pulse takes it to ST_RUN (transition "arm"). In ST_RUN each strobe updates the value, and a further start pulse re-arms the unit without leaving ST_RUN (transition "restart").

Top module: `loop_iter_pe`

## Requirements
- R1: A start pulse loads the output with the start value and the period counter with period−1. A period of 0 acts as a period of 1. The next iteration is therefore the first of a period.
- R2: After reset the output is 0 and the unit is in ST_IDLE. Iteration strobes before the first start pulse leave the output unchanged.
- R3: The output changes only on a clock edge where a start pulse or an accepted iteration strobe is present.
- R4: With period P, every P-th accepted strobe after a start (the P-th, 2P-th, …) is a period boundary. This counting is the same in every mode.
- R5: Mode code 1 (resetting). At a boundary strobe the output becomes the start value. At any other strobe it becomes output op step.
- R6: Mode code 0 (nested iterator). At a non-boundary strobe the output is held. At a boundary strobe it becomes output op step, unless the output currently equals the ceiling, in which case it becomes the start value. With start 0, step 1, ceiling N−1 and period P, strobe k gives (k/P) mod N.
- R7: Mode code 2 (leaping). At a boundary strobe the output becomes output op start value. At any other strobe it becomes output op step.
- R8: Mode code 3 (free). Every strobe makes the output output op step.
- R9: ALU operation codes: 0 add, 1 subtract (output minus operand), 2 multiply (low word), 3 AND, 4 OR, 5 XOR, 6 XNOR, 7 pass operand.
- R10: The step is the immediate input when the step-source select is 0, and the neighbour input when it is 1.
- R11: If a start pulse and a strobe come in the same cycle, the start pulse takes effect and the strobe is dropped.
- R12: Host writes with select 0, 1 and 2 set the start value, period and ceiling respectively. Select 3 changes none of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Host parameter write strobe |
| cfg_sel | input | 2 | Parameter select: 0 start, 1 period, 2 ceiling, 3 none |
| cfg_wdata | input | W | Parameter write data |
| mode | input | 2 | 0 nested, 1 resetting, 2 leaping, 3 free |
| alu_op | input | 3 | ALU operation code (see R9) |
| delta_src | input | 1 | Step source: 0 immediate, 1 neighbour |
| imm_delta | input | W | Immediate step value |
| nbr_delta | input | W | Step value from the neighbouring element |
| start | input | 1 | Arm / re-arm pulse |
| iter_stb | input | 1 | One pulse per loop iteration |
| acc_out | output | W | Iterator / accumulator value |

## Verification
The bench aims at the wrap in nested mode: a design that compares with the ceiling one iteration late, or at every strobe rather than only at a boundary, gives a sequence that skips or repeats its top value. Several corner cases are driven directly. A period of 0 or 1, where every strobe is a boundary, catches a counter that underflows. Strobes on consecutive cycles catch an update that depends on gaps between them. A start pulse together with a strobe catches a design that lets the strobe through. Leaping and resetting runs check that the start value is used as an operand or as a replacement on exactly the boundary strobes. Random runs across modes, operations, periods and strobe gaps are compared against a model of the requirements, which catches a wrong operand order or a wrong operation code.

// File: rtl/lip_pkg.sv
package lip_pkg;

    typedef enum logic [1:0] {
        MODE_NEST  = 2'd0,
        MODE_RESET = 2'd1,
        MODE_LEAP  = 2'd2,
        MODE_FREE  = 2'd3
    } lip_mode_e;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_XOR  = 3'd5,
        OP_XNOR = 3'd6,
        OP_PASS = 3'd7
    } lip_op_e;

    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_PER   = 2'd1,
        SEL_CEIL  = 2'd2,
        SEL_NONE  = 2'd3
    } lip_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } lip_state_e;

endpackage

// File: rtl/lip_cfg_regs.sv
module lip_cfg_regs
    import lip_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  lip_sel_e     sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] start_val,
    output logic [W-1:0] period,
    output logic [W-1:0] ceiling
);
    localparam logic [W-1:0] PER_RST = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_val <= '0;
            period    <= PER_RST;
            ceiling   <= '0;
        end else if (wr) begin
            unique case (sel)
                SEL_START: start_val <= wdata;
                SEL_PER:   period    <= wdata;
                SEL_CEIL:  ceiling   <= wdata;
                SEL_NONE:  ;
            endcase
        end
    end

    // R12: the unused select leaves every parameter alone
    a_r12_none_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_NONE) |=> ($stable(start_val) && $stable(period) && $stable(ceiling)));

endmodule

// File: rtl/lip_period_ctr.sv
module lip_period_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] period,
    output logic         boundary
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] reload;

    always_comb begin
        reload = (period == '0) ? '0 : period - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload;
        end else if (step) begin
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - W'(1);
        end
    end

    assign boundary = (cnt_q == '0);

    // R4: between boundaries the counter moves down by exactly one per step
    a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

    // R1: a load leaves the counter at period-1 (0 for periods 0 and 1)
    a_r1_ctr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load && $stable(period)) |=> (cnt_q == ((period == '0) ? '0 : period - W'(1))));

endmodule

// File: rtl/lip_alu.sv
module lip_alu
    import lip_pkg::*;
#(
    parameter int W = 16
) (
    input  lip_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int PW = 2 * W;
    logic [PW-1:0] prod;

    always_comb begin
        prod = PW'(a) * PW'(b);
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = prod[W-1:0];
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_XNOR: y = ~(a ^ b);
            OP_PASS: y = b;
        endcase
    end

endmodule

// File: rtl/lip_seq.sv
module lip_seq
    import lip_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         iter_stb,
    input  lip_mode_e    mode,
    input  logic         boundary,
    input  logic [W-1:0] start_val,
    input  logic [W-1:0] ceiling,
    input  logic [W-1:0] alu_y,
    output logic         ctr_load,
    output logic         ctr_step,
    output logic         leap_operand,
    output logic [W-1:0] acc_q
);
    lip_state_e   state_q, state_d;
    logic         wrap_q;
    logic [W-1:0] nxt;

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_RUN : ST_IDLE;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // control outputs
    always_comb begin
        ctr_load     = start;
        ctr_step     = (state_q == ST_RUN) && iter_stb && !start;
        leap_operand = (mode == MODE_LEAP) && boundary;
    end

    // value selection; wrap_q is the registered ceiling compare
    always_comb begin
        unique case (mode)
            MODE_NEST:  nxt = boundary ? (wrap_q ? start_val : alu_y) : acc_q;
            MODE_RESET: nxt = boundary ? start_val : alu_y;
            MODE_LEAP:  nxt = alu_y;
            MODE_FREE:  nxt = alu_y;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            wrap_q <= 1'b0;
        end else if (ctr_load) begin
            acc_q  <= start_val;
            wrap_q <= (start_val == ceiling);
        end else if (ctr_step) begin
            acc_q  <= nxt;
            wrap_q <= (nxt == ceiling);
        end
    end

    // R3: no start and no strobe keeps the value
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !iter_stb) |=> $stable(acc_q));

    // R2: strobes before arming are ignored
    a_r2_idle_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> $stable(acc_q));

    // R1 and R11: start loads the start value, even with a strobe present
    a_r1_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (acc_q == $past(start_val)));

    // R5: boundary strobe in resetting mode restores the start value
    a_r5_reset_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_step && mode == MODE_RESET && boundary) |=> (acc_q == $past(start_val)));

    // R6: nested mode holds inside a period
    a_r6_nest_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_step && mode == MODE_NEST && !boundary) |=> $stable(acc_q));

endmodule

// File: rtl/loop_iter_pe.sv
module loop_iter_pe
    import lip_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic [1:0]   cfg_sel,
    input  logic [W-1:0] cfg_wdata,
    input  logic [1:0]   mode,
    input  logic [2:0]   alu_op,
    input  logic         delta_src,
    input  logic [W-1:0] imm_delta,
    input  logic [W-1:0] nbr_delta,
    input  logic         start,
    input  logic         iter_stb,
    output logic [W-1:0] acc_out
);
    logic [W-1:0] start_val, period, ceiling;
    logic [W-1:0] delta, operand_b, alu_y, acc_q;
    logic         ctr_load, ctr_step, boundary, leap_operand;

    lip_cfg_regs #(.W(W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .sel       (lip_sel_e'(cfg_sel)),
        .wdata     (cfg_wdata),
        .start_val (start_val),
        .period    (period),
        .ceiling   (ceiling)
    );

    lip_period_ctr #(.W(W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .step     (ctr_step),
        .period   (period),
        .boundary (boundary)
    );

    always_comb begin
        delta     = delta_src ? nbr_delta : imm_delta;
        operand_b = leap_operand ? start_val : delta;
    end

    lip_alu #(.W(W)) u_alu (
        .op (lip_op_e'(alu_op)),
        .a  (acc_q),
        .b  (operand_b),
        .y  (alu_y)
    );

    lip_seq #(.W(W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .iter_stb     (iter_stb),
        .mode         (lip_mode_e'(mode)),
        .boundary     (boundary),
        .start_val    (start_val),
        .ceiling      (ceiling),
        .alu_y        (alu_y),
        .ctr_load     (ctr_load),
        .ctr_step     (ctr_step),
        .leap_operand (leap_operand),
        .acc_q        (acc_q)
    );

    assign acc_out = acc_q;

endmodule

// File: tb/tb_loop_iter_pe.sv
module tb_loop_iter_pe;
    localparam int  W      = 16;
    localparam time CLK_P  = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [1:0]   cfg_sel = '0;
    logic [W-1:0] cfg_wdata = '0;
    logic [1:0]   mode = '0;
    logic [2:0]   alu_op = '0;
    logic         delta_src = 1'b0;
    logic [W-1:0] imm_delta = '0;
    logic [W-1:0] nbr_delta = '0;
    logic         start = 1'b0;
    logic         iter_stb = 1'b0;
    logic [W-1:0] acc_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model of the requirements
    logic [W-1:0] m_alpha = '0, m_rho = W'(1), m_omega = '0;
    logic [W-1:0] m_acc = '0, m_cnt = '0;
    bit           m_wrap = 1'b0;

    loop_iter_pe #(.W(W)) dut (.*);

    always #(CLK_P/2) clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [W-1:0] f_op(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] p;
        p = (2*W)'(a) * (2*W)'(b);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return p[W-1:0];
            3'd3: return a & b;
            3'd4: return a | b;
            3'd5: return a ^ b;
            3'd6: return ~(a ^ b);
            default: return b;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [1:0] sel, input logic [W-1:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        case (sel)
            2'd0: m_alpha = d;
            2'd1: m_rho = d;
            2'd2: m_omega = d;
            default: ;
        endcase
    endtask

    task automatic m_start();
        m_acc  = m_alpha;
        m_cnt  = (m_rho == '0) ? '0 : m_rho - W'(1);
        m_wrap = (m_alpha == m_omega);
    endtask

    task automatic do_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m_start();
    endtask

    task automatic m_step();
        logic [W-1:0] d, nx;
        bit bnd;
        d   = delta_src ? nbr_delta : imm_delta;
        bnd = (m_cnt == '0);
        m_cnt = bnd ? ((m_rho == '0) ? '0 : m_rho - W'(1)) : m_cnt - W'(1);
        case (mode)
            2'd0: nx = bnd ? (m_wrap ? m_alpha : f_op(alu_op, m_acc, d)) : m_acc;
            2'd1: nx = bnd ? m_alpha : f_op(alu_op, m_acc, d);
            2'd2: nx = f_op(alu_op, m_acc, bnd ? m_alpha : d);
            default: nx = f_op(alu_op, m_acc, d);
        endcase
        m_acc  = nx;
        m_wrap = (nx == m_omega);
    endtask

    task automatic strobe(input int gap);
        repeat (gap) @(negedge clk);
        iter_stb = 1'b1;
        @(negedge clk);
        iter_stb = 1'b0;
        m_step();
    endtask

    task automatic setup(input logic [1:0] md, input logic [2:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] r, input logic [W-1:0] w, input logic [W-1:0] d);
        mode = md; alu_op = op; imm_delta = d; delta_src = 1'b0;
        wr_cfg(2'd0, a);
        wr_cfg(2'd1, r);
        wr_cfg(2'd2, w);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset value", acc_out, '0);
        strobe(0);
        strobe(2);
        chk("R2 strobe in idle ignored", acc_out, '0);

        // R6 nested iterator: (k/3) mod 4
        setup(2'd0, 3'd0, '0, W'(3), W'(3), W'(1));
        do_start();
        chk("R1 start value", acc_out, '0);
        for (int k = 1; k <= 26; k++) begin
            strobe(k % 2);
            chk("R6 R4 nested sequence", acc_out, W'((k / 3) % 4));
        end

        // R5 resetting: 5 + (k mod 4)*2
        setup(2'd1, 3'd0, W'(5), W'(4), '0, W'(2));
        do_start();
        for (int k = 1; k <= 12; k++) begin
            strobe(0);
            chk("R5 resetting sequence", acc_out, W'(5 + (k % 4) * 2));
        end

        // R3 idle clocks keep the value
        repeat (5) @(negedge clk);
        chk("R3 no strobe holds", acc_out, W'(5 + (12 % 4) * 2));

        // R10 neighbour step
        delta_src = 1'b1; nbr_delta = W'(7);
        do_start();
        for (int k = 1; k <= 8; k++) begin
            strobe(1);
            chk("R10 neighbour step", acc_out, W'(5 + (k % 4) * 7));
        end
        delta_src = 1'b0;

        // R1 period 0 behaves as 1
        wr_cfg(2'd1, '0);
        do_start();
        for (int k = 1; k <= 4; k++) begin
            strobe(0);
            chk("R1 period zero as one", acc_out, W'(5));
        end

        // R7 leaping: 10 + (k/3)*10 + (k - k/3)*1
        setup(2'd2, 3'd0, W'(10), W'(3), '0, W'(1));
        do_start();
        for (int k = 1; k <= 12; k++) begin
            strobe(k % 3);
            chk("R7 leaping sequence", acc_out, W'(10 + (k / 3) * 10 + (k - k / 3)));
        end

        // R8 free mode subtract: 100 - 3k
        setup(2'd3, 3'd1, W'(100), W'(2), '0, W'(3));
        do_start();
        for (int k = 1; k <= 6; k++) begin
            strobe(0);
            chk("R8 free mode", acc_out, W'(100 - 3 * k));
        end

        // R11 start together with strobe
        @(negedge clk);
        start = 1'b1; iter_stb = 1'b1;
        @(negedge clk);
        start = 1'b0; iter_stb = 1'b0;
        m_start();
        chk("R11 start wins over strobe", acc_out, W'(100));
        strobe(0);
        chk("R11 first strobe after restart", acc_out, W'(97));

        // R12 select 3 changes nothing
        wr_cfg(2'd3, W'(555));
        do_start();
        chk("R12 select none ignored", acc_out, W'(100));

        // R9 every operation once
        for (int op = 0; op < 8; op++) begin
            setup(2'd3, 3'(op), W'(16'h00F0), W'(1), '0, W'(16'h0F3C));
            do_start();
            strobe(0);
            chk("R9 alu operation", acc_out, f_op(3'(op), W'(16'h00F0), W'(16'h0F3C)));
        end

        // random runs against the model
        for (int run = 0; run < 24; run++) begin
            setup(2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
                  W'($urandom_range(0, 6)), W'($urandom_range(0, 5)),
                  W'($urandom_range(0, 8)), W'($urandom_range(0, 3)));
            delta_src = 1'($urandom_range(0, 1));
            nbr_delta = W'($urandom_range(0, 5));
            do_start();
            chk("R1 random start", acc_out, m_acc);
            for (int k = 0; k < 20; k++) begin
                strobe($urandom_range(0, 3));
                chk("R4 R5 R6 R7 R8 random run", acc_out, m_acc);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule